// File: doc/BRIEF.md
# Hysteretic Input Level Detector

This block watches the magnitude of an incoming sample stream and raises a level indicator when the signal gets loud. Only the ten most significant bits of the sample magnitude are compared, against two programmable ten-bit thresholds. The indicator turns on as soon as the upper threshold is reached. It turns off only after the signal has stayed at or below the lower threshold for a programmable number of consecutive clock cycles. This hysteresis and hold time keep the indicator from chattering on a signal that hovers near a single threshold.

Any climb out of the low zone restarts the hold period. A climb back to the upper threshold also cancels the pending release. A hold count of zero switches the detector off. A polarity input selects whether the pin is active-high or active-low. One detector channel is built. The configuration inputs are expected to be held stable by the surrounding register logic.

Top module: `level_detect`

## Requirements
- R1: After reset the indicator is inactive, so `level_o` equals `invert_i`.
- R2: When the top ten bits of `sample_i` are greater than or equal to `thr_hi_i` and `dwell_i` is nonzero, the indicator is active from the next clock edge.
- R3: Once active, the indicator goes inactive on the clock edge at which the N-th consecutive sample with top bits less than or equal to `thr_lo_i` is registered, where N = `dwell_i`.
- R4: A sample whose top bits lie strictly between the thresholds restarts the hold count. The indicator then needs a fresh run of N low samples to release.
- R5: A sample at or above the upper threshold during a hold cancels the countdown and keeps the indicator active. The release again needs N consecutive low samples.
- R6: When `dwell_i` is zero, the indicator is inactive from the next clock edge, whatever the sample is, including when it was already active.
- R7: While the indicator is inactive, samples below the upper threshold leave it inactive.
- R8: With `invert_i` = 0, `level_o` is 1 when the indicator is active. With `invert_i` = 1, `level_o` is 0 when the indicator is active.
- R9: The low bits of `sample_i` below the top ten have no effect on `level_o`.
- R10: When a sample meets both thresholds at once (overlapping settings), the upper threshold wins and the indicator is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | MAG_W (16) | Sample magnitude; top 10 bits compared |
| thr_lo_i | input | 10 | Lower (release) threshold |
| thr_hi_i | input | 10 | Upper (trigger) threshold |
| dwell_i | input | DWELL_W (20) | Consecutive low cycles before release; 0 disables |
| invert_i | input | 1 | 1 = indicator active-low |
| level_o | output | 1 | Level indicator pin |

## Verification
The bench counts cycles exactly across the release. It checks that the indicator is still on after N-1 low samples and off after the N-th. A design that is off by one in its counter would release a cycle early or late. Hold runs are interrupted by a middle-zone sample and by an upper-threshold sample, so a design that paused instead of reloading its count would release too soon. The bench also covers a hold of one, a hold of zero applied both idle and while active, a large hold count, overlapping thresholds, inverted polarity, and noisy low-order bits. Each of these catches a design that mishandles one edge of the comparison or the enable.

// File: rtl/lvl_det_pkg.sv
package lvl_det_pkg;
    localparam int THR_W = 10;

    typedef enum logic [1:0] {
        ZONE_LOW  = 2'd0,
        ZONE_MID  = 2'd1,
        ZONE_HIGH = 2'd2
    } zone_e;
endpackage

// File: rtl/lvl_det_zone.sv
module lvl_det_zone
    import lvl_det_pkg::*;
#(
    parameter int MAG_W = 16
) (
    input  logic [MAG_W-1:0] sample_i,
    input  logic [THR_W-1:0] thr_lo_i,
    input  logic [THR_W-1:0] thr_hi_i,
    output zone_e            zone_o
);
    localparam int TOP_LSB = MAG_W - THR_W;

    logic [THR_W-1:0] top;
    assign top = sample_i[MAG_W-1:TOP_LSB];

    // Upper threshold takes precedence when settings overlap.
    always_comb begin
        if (top >= thr_hi_i)      zone_o = ZONE_HIGH;
        else if (top <= thr_lo_i) zone_o = ZONE_LOW;
        else                      zone_o = ZONE_MID;
    end
endmodule

// File: rtl/lvl_det_hold.sv
module lvl_det_hold
    import lvl_det_pkg::*;
#(
    parameter int DWELL_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  zone_e              zone_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output logic               active_o
);
    typedef struct packed {
        logic               active;
        logic               holding;
        logic [DWELL_W-1:0] remain;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     enabled;

    assign enabled = (dwell_i != '0);

    always_comb begin
        st_d = st_q;
        if (!enabled) begin
            st_d.active  = 1'b0;
            st_d.holding = 1'b0;
            st_d.remain  = '0;
        end else if (zone_i == ZONE_HIGH) begin
            st_d.active  = 1'b1;
            st_d.holding = 1'b0;
        end else if (st_q.active) begin
            if (zone_i == ZONE_LOW) begin
                if (!st_q.holding) begin
                    if (dwell_i == DWELL_W'(1)) begin
                        st_d.active = 1'b0;
                    end else begin
                        st_d.holding = 1'b1;
                        st_d.remain  = dwell_i - DWELL_W'(1);
                    end
                end else if (st_q.remain == DWELL_W'(1)) begin
                    st_d.active  = 1'b0;
                    st_d.holding = 1'b0;
                end else begin
                    st_d.remain = st_q.remain - DWELL_W'(1);
                end
            end else begin
                st_d.holding = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;

    // R2
    hi_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_i == ZONE_HIGH && dwell_i != '0) |=> st_q.active);

    // R6
    zero_dwell_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_i == '0) |=> !st_q.active);

    // R3
    release_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.active) |-> $past(zone_i == ZONE_LOW || dwell_i == '0));

    // R7
    idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && zone_i != ZONE_HIGH) |=> !st_q.active);

    // R5
    hold_implies_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.holding |-> st_q.active);
endmodule

// File: rtl/level_detect.sv
module level_detect
    import lvl_det_pkg::*;
#(
    parameter int MAG_W   = 16,
    parameter int DWELL_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MAG_W-1:0]   sample_i,
    input  logic [9:0]         thr_lo_i,
    input  logic [9:0]         thr_hi_i,
    input  logic [DWELL_W-1:0] dwell_i,
    input  logic               invert_i,
    output logic               level_o
);
    zone_e zone;
    logic  active;

    lvl_det_zone #(.MAG_W(MAG_W)) u_zone (
        .sample_i (sample_i),
        .thr_lo_i (thr_lo_i),
        .thr_hi_i (thr_hi_i),
        .zone_o   (zone)
    );

    lvl_det_hold #(.DWELL_W(DWELL_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .zone_i   (zone),
        .dwell_i  (dwell_i),
        .active_o (active)
    );

    assign level_o = invert_i ? ~active : active;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (level_o == invert_i) || rst_n);
endmodule

// File: tb/sim_level_detect.sv
module sim_level_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sample = '0;
    logic [9:0]  thr_lo = 10'd100;
    logic [9:0]  thr_hi = 10'd500;
    logic [19:0] dwell = 20'd4;
    logic        invert = 1'b0;
    logic        level;
    logic [5:0]  noise = 6'd0;
    int          vectors = 0;
    int          miscompares = 0;

    always #2 clk = ~clk;

    level_detect u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .thr_lo_i(thr_lo),
        .thr_hi_i(thr_hi), .dwell_i(dwell), .invert_i(invert), .level_o(level)
    );

    task automatic check(input logic exp, input string req);
        vectors++;
        if (level !== exp) begin
            miscompares++;
            $display("FAIL %s: level_o=%b expected %b at %0t", req, level, exp, $time);
        end
    endtask

    task automatic apply(input logic [9:0] top, input logic exp, input string req);
        @(negedge clk);
        sample = {top, noise};
        @(posedge clk);
        #1;
        check(exp, req);
    endtask

    task automatic go_idle();
        @(negedge clk);
        dwell = 20'd0;
        sample = '0;
        @(posedge clk);
        #1;
        @(negedge clk);
        dwell = 20'd4;
    endtask

    task automatic t_reset();
        #1 check(1'b0, "R1 reset");
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        go_idle();
        apply(10'd499, 1'b0, "R7 below upper");
        apply(10'd300, 1'b0, "R7 mid zone");
        apply(10'd500, 1'b1, "R2 at upper");
        for (int i = 0; i < 3; i++) apply(10'd100, 1'b1, "R3 hold");
        apply(10'd100, 1'b0, "R3 release on Nth");
    endtask

    task automatic t_mid_restart();
        go_idle();
        apply(10'd700, 1'b1, "R2 above upper");
        apply(10'd50, 1'b1, "R4 low1");
        apply(10'd50, 1'b1, "R4 low2");
        apply(10'd101, 1'b1, "R4 mid interrupt");
        for (int i = 0; i < 3; i++) apply(10'd0, 1'b1, "R4 refreshed hold");
        apply(10'd0, 1'b0, "R4 release");
    endtask

    task automatic t_hi_cancel();
        go_idle();
        apply(10'd600, 1'b1, "R2 trigger");
        apply(10'd10, 1'b1, "R5 low1");
        apply(10'd10, 1'b1, "R5 low2");
        apply(10'd10, 1'b1, "R5 low3");
        apply(10'd600, 1'b1, "R5 recross");
        for (int i = 0; i < 3; i++) apply(10'd10, 1'b1, "R5 hold again");
        apply(10'd10, 1'b0, "R5 release");
    endtask

    task automatic t_dwell_one();
        go_idle();
        @(negedge clk) dwell = 20'd1;
        apply(10'd1023, 1'b1, "R2 dwell1 trigger");
        apply(10'd100, 1'b0, "R3 dwell1 release");
    endtask

    task automatic t_dwell_zero();
        go_idle();
        apply(10'd900, 1'b1, "R2 trigger");
        @(negedge clk) dwell = 20'd0;
        apply(10'd900, 1'b0, "R6 zero while active");
        apply(10'd1000, 1'b0, "R6 zero ignores high");
        @(negedge clk) dwell = 20'd4;
    endtask

    task automatic t_polarity();
        go_idle();
        @(negedge clk) invert = 1'b1;
        #1 check(1'b1, "R8 inverted idle");
        apply(10'd500, 1'b0, "R8 inverted active");
        for (int i = 0; i < 4; i++) apply(10'd0, (i == 3), "R8 inverted release");
        @(negedge clk) invert = 1'b0;
    endtask

    task automatic t_noise();
        go_idle();
        noise = 6'h3F;
        apply(10'd499, 1'b0, "R9 noisy below upper");
        apply(10'd500, 1'b1, "R9 noisy trigger");
        for (int i = 0; i < 4; i++) apply(10'd100, (i != 3), "R9 noisy low");
        noise = 6'd0;
    endtask

    task automatic t_overlap();
        go_idle();
        @(negedge clk) begin thr_lo = 10'd400; thr_hi = 10'd300; end
        apply(10'd350, 1'b1, "R10 overlap upper wins");
        apply(10'd350, 1'b1, "R10 overlap held");
        @(negedge clk) begin thr_lo = 10'd100; thr_hi = 10'd500; end
    endtask

    task automatic t_long();
        go_idle();
        @(negedge clk) dwell = 20'd1000;
        apply(10'd800, 1'b1, "R2 long trigger");
        for (int i = 0; i < 999; i++) begin
            @(negedge clk) sample = {10'd20, noise};
            @(posedge clk);
        end
        #1 check(1'b1, "R3 long N-1");
        apply(10'd20, 1'b0, "R3 long Nth");
        @(negedge clk) dwell = 20'd4;
    endtask

    initial begin
        #(4 * 200000);
        miscompares++;
        $display("FAIL watchdog: expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #3;
        t_reset();
        t_basic();
        t_mid_restart();
        t_hi_cancel();
        t_dwell_one();
        t_dwell_zero();
        t_polarity();
        t_noise();
        t_overlap();
        t_long();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule